// File: doc/BRIEF.md
# T1 Receive Loss-of-Sync Indicator

This block produces the receive loss-of-sync flag of a T1 receiver, where each frame is 193 bits long and starts with an F-bit. It watches the serial receive stream one bit at a time, using a bit-clock enable. It counts runs of consecutive zero bits to detect that the line carrier has gone. It raises the flag when a resynchronisation begins, either because the framer reports an out-of-frame F-bit or because carrier is lost. The frame search itself lives in a neighbouring framer. That framer signals, with a single pulse, that it has declared a new alignment, and it marks every F-bit position with a strobe.

Once the new alignment is declared, the flag is held through the first complete frame that follows. It drops on the last bit of that frame, which is one bit period before the F-bit of the second frame after realignment. An automatic/manual mode bit decides what can start a resync. In automatic mode, out-of-frame and carrier loss start it. In manual mode only an explicit request does. An elaboration option selects the carrier-loss run length: the long run of 128 zeros or the short run of 32.

Every event input is qualified by the bit-clock enable. The flag is a register output, so it changes at the clock edge that samples the triggering bit.

Top module: `t1_rx_sync_loss`

## Requirements
- R1: After reset `sync_lost` is 0.
- R2: The consecutive-zero count advances only on cycles where `bit_en` is 1 and `rx_data` is 0. A sampled 1 clears it. Cycles with `bit_en` at 0 leave it unchanged, whatever `rx_data` carries.
- R3: With `SHORT_RUN` = 0 and `manual_resync` = 0, `sync_lost` goes to 1 at the edge that samples the 128th consecutive zero, and not earlier.
- R4: With `SHORT_RUN` = 1, the same rise happens at the 32nd consecutive zero.
- R5: With `manual_resync` = 0, a bit sampled with `oof_pulse` = 1 sets `sync_lost` to 1 at that edge.
- R6: With `manual_resync` = 1, neither `oof_pulse` nor any length of zero run changes `sync_lost`.
- R7: A bit sampled with `resync_req` = 1 sets `sync_lost` when `manual_resync` = 1, and is ignored when `manual_resync` = 0.
- R8: After a bit with `align_done` = 1 is sampled while `sync_lost` is 1, frame 1 begins at the next bit with `fbit_strobe` = 1. Frame positions are counted from 0 at that F-bit. `sync_lost` falls at the edge sampling position 192 of frame 1, one bit before the F-bit of frame 2.
- R9: `align_done` sampled while `sync_lost` is 0 has no effect.
- R10: A resync start sampled while `sync_lost` is 1 keeps the flag high and cancels any pending release. This holds even when the start falls on the same bit as `align_done`, and the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle bit-clock enable; all other event inputs are sampled only with it |
| rx_data | input | 1 | Serial receive data bit |
| fbit_strobe | input | 1 | Marks the current bit as an F-bit (frame position 0) |
| oof_pulse | input | 1 | Out-of-frame report, aligned to the offending F-bit |
| align_done | input | 1 | Framer has declared a new alignment |
| manual_resync | input | 1 | 0: automatic resync, 1: manual resync |
| resync_req | input | 1 | Explicit resync request (manual mode) |
| sync_lost | output | 1 | Receive loss-of-sync flag |

## Verification
Two kinds of event can land on the same sampled bit. One is the end of a zero run and the framer's out-of-frame report. The other is a resync start and the alignment-declared pulse. The bench builds a run of 127 zeros that ends just before an F-bit, then sends that F-bit as a zero with the out-of-frame report set. It expects a single clean rise on that bit. It also pulses out-of-frame and alignment together on one F-bit while the flag is already high. In that case the flag must stay high past the point where a release would otherwise have happened, because the start outranks the alignment.

// File: rtl/t1los_pkg.sv
package t1los_pkg;

   typedef enum logic [1:0] {
      LS_INSYNC = 2'd0,
      LS_HUNT   = 2'd1,
      LS_ARMED  = 2'd2,
      LS_FRAME1 = 2'd3
   } los_state_t;

   function automatic int unsigned run_limit(input bit short_run,
                                             input int unsigned long_zeros,
                                             input int unsigned short_zeros);
      return short_run ? short_zeros : long_zeros;
   endfunction

endpackage

// File: rtl/t1los_zero_run.sv
module t1los_zero_run #(
   parameter int unsigned THRESH = 128,
   localparam int unsigned CW = $clog2(THRESH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_data,
   output logic run_hit
);

   generate
      if (THRESH < 2) begin : g_bad_thresh
         $error("t1los_zero_run: THRESH must be at least 2");
      end
   endgenerate

   logic [CW-1:0] run_cnt;
   logic          at_edge;

   assign at_edge = (run_cnt == CW'(THRESH - 1));
   assign run_hit = bit_en && !rx_data && at_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (bit_en) begin
         if (rx_data) begin
            run_cnt <= '0;
         end else if (run_cnt != CW'(THRESH)) begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= CW'(THRESH));

   assert_one_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && rx_data) |=> (run_cnt == '0));

   assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(run_cnt));

   assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_hit |=> !run_hit);

endmodule

// File: rtl/t1los_frame_pos.sv
module t1los_frame_pos #(
   parameter int unsigned FRAME_BITS = 193,
   localparam int unsigned PW = $clog2(FRAME_BITS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic fbit_strobe,
   output logic last_bit
);

   generate
      if (FRAME_BITS < 3) begin : g_bad_frame
         $error("t1los_frame_pos: FRAME_BITS must be at least 3");
      end
   endgenerate

   logic [PW-1:0] pos;

   assign last_bit = bit_en && !fbit_strobe && (pos == PW'(FRAME_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (bit_en) begin
         if (fbit_strobe) begin
            pos <= PW'(1);
         end else if (pos == PW'(FRAME_BITS - 1)) begin
            pos <= '0;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end

   assert_pos_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pos < PW'(FRAME_BITS));

   assert_fbit_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && fbit_strobe) |=> (pos == PW'(1)));

endmodule

// File: rtl/t1los_ctrl.sv
module t1los_ctrl
   import t1los_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic fbit_strobe,
   input  logic oof_pulse,
   input  logic run_hit,
   input  logic align_done,
   input  logic manual_resync,
   input  logic resync_req,
   input  logic last_bit,
   output logic sync_lost
);

   los_state_t state, state_nx;
   logic       auto_start;
   logic       manual_start;
   logic       start;

   assign auto_start   = !manual_resync && (oof_pulse || run_hit);
   assign manual_start = manual_resync && resync_req;
   assign start        = bit_en && (auto_start || manual_start);

   always_comb begin
      state_nx = state;
      if (start) begin
         state_nx = LS_HUNT;
      end else if (bit_en) begin
         unique case (state)
            LS_INSYNC: state_nx = LS_INSYNC;
            LS_HUNT:   if (align_done) state_nx = LS_ARMED;
            LS_ARMED:  if (fbit_strobe) state_nx = LS_FRAME1;
            LS_FRAME1: if (last_bit) state_nx = LS_INSYNC;
            default:   state_nx = LS_INSYNC;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LS_INSYNC;
      end else begin
         state <= state_nx;
      end
   end

   assign sync_lost = (state != LS_INSYNC);

   assert_oof_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && oof_pulse && !manual_resync) |=> sync_lost);

   assert_manual_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_lost && manual_resync && !(bit_en && resync_req)) |=> !sync_lost);

   assert_auto_req_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_lost && !manual_resync && !(bit_en && (oof_pulse || run_hit)))
      |=> !sync_lost);

   assert_fall_on_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_lost) |-> $past(bit_en && last_bit));

   assert_start_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (state == LS_HUNT));

endmodule

// File: rtl/t1_rx_sync_loss.sv
module t1_rx_sync_loss
   import t1los_pkg::*;
#(
   parameter int unsigned FRAME_BITS  = 193,
   parameter bit          SHORT_RUN   = 1'b0,
   parameter int unsigned LONG_ZEROS  = 128,
   parameter int unsigned SHORT_ZEROS = 32,
   localparam int unsigned RUN_LIMIT  = run_limit(SHORT_RUN, LONG_ZEROS, SHORT_ZEROS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_data,
   input  logic fbit_strobe,
   input  logic oof_pulse,
   input  logic align_done,
   input  logic manual_resync,
   input  logic resync_req,
   output logic sync_lost
);

   generate
      if (SHORT_ZEROS >= LONG_ZEROS) begin : g_bad_runs
         $error("t1_rx_sync_loss: SHORT_ZEROS must be below LONG_ZEROS");
      end
   endgenerate

   logic run_hit;
   logic last_bit;

   generate
      if (SHORT_RUN) begin : g_short_run
         t1los_zero_run #(.THRESH(SHORT_ZEROS)) u_run (
            .clk     (clk),
            .rst_n   (rst_n),
            .bit_en  (bit_en),
            .rx_data (rx_data),
            .run_hit (run_hit)
         );
      end else begin : g_long_run
         t1los_zero_run #(.THRESH(LONG_ZEROS)) u_run (
            .clk     (clk),
            .rst_n   (rst_n),
            .bit_en  (bit_en),
            .rx_data (rx_data),
            .run_hit (run_hit)
         );
      end
   endgenerate

   t1los_frame_pos #(.FRAME_BITS(FRAME_BITS)) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .fbit_strobe (fbit_strobe),
      .last_bit    (last_bit)
   );

   t1los_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .bit_en        (bit_en),
      .fbit_strobe   (fbit_strobe),
      .oof_pulse     (oof_pulse),
      .run_hit       (run_hit),
      .align_done    (align_done),
      .manual_resync (manual_resync),
      .resync_req    (resync_req),
      .last_bit      (last_bit),
      .sync_lost     (sync_lost)
   );

   assert_reset_low_R1: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || !sync_lost));

   assert_idle_cycle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(sync_lost));

   assert_align_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_lost && bit_en && align_done && !oof_pulse && !resync_req &&
       !run_hit) |=> !sync_lost);

   assert_run_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_hit && !manual_resync) |=> sync_lost);

endmodule

// File: tb/sim_t1_rx_sync_loss.sv
`timescale 1ns/1ps
module sim_t1_rx_sync_loss;

   localparam int FB = 193;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic rx_data = 1'b0;
   logic fbit_strobe = 1'b0;
   logic oof_pulse = 1'b0;
   logic align_done = 1'b0;
   logic manual_resync = 1'b0;
   logic resync_req = 1'b0;
   logic lost_l;
   logic lost_s;

   int vectors = 0;
   int fails = 0;
   int pos = 0;

   always #2 clk = ~clk;

   t1_rx_sync_loss #(.SHORT_RUN(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_data(rx_data),
      .fbit_strobe(fbit_strobe), .oof_pulse(oof_pulse), .align_done(align_done),
      .manual_resync(manual_resync), .resync_req(resync_req), .sync_lost(lost_l)
   );

   t1_rx_sync_loss #(.SHORT_RUN(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_data(rx_data),
      .fbit_strobe(fbit_strobe), .oof_pulse(oof_pulse), .align_done(align_done),
      .manual_resync(manual_resync), .resync_req(resync_req), .sync_lost(lost_s)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: sync_lost=%0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic d, input logic o, input logic a, input logic r);
      bit_en = 1'b1;
      rx_data = d;
      fbit_strobe = (pos == 0);
      oof_pulse = o;
      align_done = a;
      resync_req = r;
      @(posedge clk);
      @(negedge clk);
      bit_en = 1'b0;
      rx_data = 1'b0;
      fbit_strobe = 1'b0;
      oof_pulse = 1'b0;
      align_done = 1'b0;
      resync_req = 1'b0;
      @(posedge clk);
      @(negedge clk);
      pos = (pos + 1) % FB;
   endtask

   task automatic ones_until(input int p);
      while (pos != p) send_bit(1'b1, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic zeros(input int n);
      for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   // Declares alignment, walks through frame 1 and checks the release point (R8).
   task automatic realign(input string tag, input logic e0, input logic e1);
      ones_until(5);
      send_bit(1'b1, 1'b0, 1'b1, 1'b0);
      ones_until(0);
      send_bit(1'b1, 1'b0, 1'b0, 1'b0);
      ones_until(FB - 1);
      chk({tag, " R8 held at pos 191 (long)"}, lost_l, e0);
      chk({tag, " R8 held at pos 191 (short)"}, lost_s, e1);
      send_bit(1'b1, 1'b0, 1'b0, 1'b0);
      chk({tag, " R8 released at pos 192 (long)"}, lost_l, 1'b0);
      chk({tag, " R8 released at pos 192 (short)"}, lost_s, 1'b0);
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset (long)", lost_l, 1'b0);
      chk("R1 reset (short)", lost_s, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", lost_l, 1'b0);

      // R4 sweep around the short threshold; idle cycles carry zeros too (R2)
      for (int len = 29; len <= 34; len++) begin
         send_bit(1'b1, 1'b0, 1'b0, 1'b0);
         zeros(len);
         chk($sformatf("R4 run %0d long", len), lost_l, 1'b0);
         chk($sformatf("R4 run %0d short", len), lost_s, logic'(len >= 32));
         realign("R4", 1'b0, logic'(len >= 32));
      end

      // R3 sweep around the long threshold
      for (int len = 126; len <= 130; len++) begin
         send_bit(1'b1, 1'b0, 1'b0, 1'b0);
         zeros(len);
         chk($sformatf("R3 run %0d long", len), lost_l, logic'(len >= 128));
         chk($sformatf("R3 run %0d short", len), lost_s, 1'b1);
         realign("R3", logic'(len >= 128), 1'b1);
      end

      // R2: a single one restarts the count; gaps without bit_en do not count
      send_bit(1'b1, 1'b0, 1'b0, 1'b0);
      zeros(20);
      chk("R2 20 zeros over 40 zero cycles (short)", lost_s, 1'b0);
      zeros(80);
      send_bit(1'b1, 1'b0, 1'b0, 1'b0);
      zeros(100);
      chk("R2 100+1+100 no loss (long)", lost_l, 1'b0);
      realign("R2", 1'b0, 1'b1);

      // R5: out-of-frame on the F-bit
      ones_until(0);
      chk("R5 before oof", lost_l, 1'b0);
      send_bit(1'b1, 1'b1, 1'b0, 1'b0);
      chk("R5 oof rise (long)", lost_l, 1'b1);
      chk("R5 oof rise (short)", lost_s, 1'b1);
      realign("R5", 1'b1, 1'b1);

      // R9: alignment while in sync is ignored
      ones_until(10);
      send_bit(1'b1, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 2 * FB + 5; i++) send_bit(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R9 align ignored (long)", lost_l, 1'b0);
      chk("R9 align ignored (short)", lost_s, 1'b0);

      // R6 / R7 manual mode
      manual_resync = 1'b1;
      ones_until(0);
      send_bit(1'b1, 1'b1, 1'b0, 1'b0);
      chk("R6 manual oof ignored", lost_l, 1'b0);
      zeros(140);
      chk("R6 manual zero run ignored (long)", lost_l, 1'b0);
      chk("R6 manual zero run ignored (short)", lost_s, 1'b0);
      send_bit(1'b1, 1'b0, 1'b0, 1'b1);
      chk("R7 manual request (long)", lost_l, 1'b1);
      chk("R7 manual request (short)", lost_s, 1'b1);
      realign("R7", 1'b1, 1'b1);
      manual_resync = 1'b0;
      send_bit(1'b1, 1'b0, 1'b0, 1'b1);
      chk("R7 auto request ignored", lost_l, 1'b0);

      // R10: restart during the wait cancels the pending release
      ones_until(0);
      send_bit(1'b1, 1'b1, 1'b0, 1'b0);
      ones_until(5);
      send_bit(1'b1, 1'b0, 1'b1, 1'b0);
      ones_until(0);
      send_bit(1'b1, 1'b0, 1'b0, 1'b0);
      ones_until(100);
      send_bit(1'b1, 1'b1, 1'b0, 1'b0);
      ones_until(FB - 1);
      send_bit(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R10 restart cancels release", lost_l, 1'b1);
      realign("R10", 1'b1, 1'b1);

      // R10: out-of-frame and alignment on the same F-bit, start wins
      ones_until(0);
      send_bit(1'b1, 1'b1, 1'b0, 1'b0);
      ones_until(0);
      send_bit(1'b1, 1'b1, 1'b1, 1'b0);
      ones_until(0);
      send_bit(1'b1, 1'b0, 1'b0, 1'b0);
      ones_until(FB - 1);
      send_bit(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R10 start beats same-bit align", lost_l, 1'b1);
      realign("R10b", 1'b1, 1'b1);

      // R3 + R5 on the same bit: 128th zero is an oof F-bit
      ones_until(FB - 127);
      zeros(127);
      chk("R3 127 zeros before F-bit", lost_l, 1'b0);
      send_bit(1'b0, 1'b1, 1'b0, 1'b0);
      chk("R3 R5 coincident rise", lost_l, 1'b1);
      realign("R3c", 1'b1, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule